// File: doc/BRIEF.md
# Per-CPU Level Interrupt Router

This block gathers a parameterised set of level-sensitive peripheral interrupt lines (32, 64 or 128) and produces one interrupt request per CPU. Every CPU owns a private bank of registers. The bank holds one mask word and one pending word for every group of 32 sources. A source reaches a CPU only when that CPU's mask bit for the source is set. Any source can therefore be steered to any subset of CPUs.

Software reaches the banks through a simple word-wide register bus. A mask word is changed by read-modify-write, because the block has no set or clear aliases. The block has no priority logic and no vectoring. A CPU that takes the interrupt reads every pending word in its own bank to find the sources that are active. Pending bits follow the input levels directly, so a source stays visible until its peripheral drops the line.

Top module: `cpu_irq_router`

## Requirements
- R1: The source count NUM_SRC is a parameter limited to 32, 64 or 128. Each bank holds WORDS = NUM_SRC/32 mask words and WORDS pending words. Any other value stops elaboration.
- R2: The bank of CPU c occupies the byte range starting at c*8*WORDS. Within a bank, mask word k sits at byte offset 4*k and pending word k sits at byte offset 4*(WORDS+k). Bit n of word k belongs to source 32*k+n. Address bits [1:0] are ignored.
- R3: Mask words are plain read/write. A write with bus_sel=1 and bus_wr=1 replaces the whole addressed word on that clock edge.
- R4: Pending word k of CPU c reads as the current level of sources 32k..32k+31, ANDed with CPU c's mask word k. It is not latched.
- R5: A write to a pending word changes no register and no output.
- R6: cpu_irq[c] is a register that loads the OR of all masked pending bits of CPU c. It changes one clock edge after the inputs or the mask change.
- R7: A write to one CPU's bank leaves the banks of all other CPUs unchanged. One source may be enabled in several banks at the same time.
- R8: While rst_n is low, every mask bit and every cpu_irq bit is cleared. Out of reset, no output asserts until software sets a mask bit.
- R9: A byte address at or beyond NUM_CPU*8*WORDS reads as zero. A write to such an address has no effect.
- R10: bus_rdata is combinational. It shows the addressed register in the same cycle while bus_sel=1 and bus_wr=0, and it is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src | input | NUM_SRC | Level interrupt lines, bit i is source i |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| cpu_irq | output | NUM_CPU | Interrupt request, one bit per CPU |

## Verification
A behavioural model is compared with the design on every clock, under four kinds of stimulus. A single source enabled in a single bank shows that the one-cycle output delay and the mask are right. The same source enabled in several banks, and distinct sources in distinct banks, expose any leakage between banks. Writes to pending words, to unused addresses and to addresses with nonzero low bits separate correct decoding from aliasing. A long random mix of line toggles and bus accesses covers all the words at once.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
   localparam int unsigned WORD_BITS = 32;
   typedef logic [WORD_BITS-1:0] word_t;

   function automatic int unsigned words_for(input int unsigned n_src);
      return n_src / WORD_BITS;
   endfunction

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/irqr_addr_dec.sv
module irqr_addr_dec
   import irqr_pkg::*;
#(
   parameter int unsigned NUM_CPU = 3,
   parameter int unsigned WORDS   = 2,
   parameter int unsigned ADDR_W  = 8,
   localparam int unsigned CPU_W  = idx_width(NUM_CPU),
   localparam int unsigned WIDX_W = idx_width(WORDS),
   localparam int unsigned PAIR   = 2 * WORDS
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [CPU_W-1:0]  cpu,
   output logic              is_stat,
   output logic [WIDX_W-1:0] widx
);
   // R2: word address split into bank number and offset inside the bank
   always_comb begin
      int unsigned wa;
      int unsigned bank;
      int unsigned off;
      wa      = 32'(addr >> 2);
      bank    = wa / PAIR;
      off     = wa % PAIR;
      hit     = (bank < NUM_CPU);
      cpu     = CPU_W'(bank);
      is_stat = (off >= WORDS);
      widx    = WIDX_W'(is_stat ? off - WORDS : off);
   end
endmodule

// File: rtl/irqr_cpu_bank.sv
module irqr_cpu_bank
   import irqr_pkg::*;
#(
   parameter int unsigned WORDS  = 2,
   localparam int unsigned NBITS = WORDS * WORD_BITS,
   localparam int unsigned WIDX_W = idx_width(WORDS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NBITS-1:0]  src,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] widx,
   input  word_t             wdata,
   output logic [NBITS-1:0]  mask,
   output logic [NBITS-1:0]  pend,
   output logic              irq_o
);
   genvar k;
   generate
      for (k = 0; k < WORDS; k++) begin : g_word
         // R3: whole-word replace
         always_ff @(posedge clk) begin
            if (!rst_n)
               mask[k*WORD_BITS +: WORD_BITS] <= '0;
            else if (wr_en && (widx == WIDX_W'(k)))
               mask[k*WORD_BITS +: WORD_BITS] <= wdata;
         end
      end
   endgenerate

   // R4: pending is live level gated by the mask
   assign pend = src & mask;

   // R6: registered OR
   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |pend;
   end

   // R6
   no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(|src));
   // R8
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |=> !irq_o);
endmodule

// File: rtl/cpu_irq_router.sv
module cpu_irq_router
   import irqr_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned NUM_CPU = 3,
   parameter int unsigned ADDR_W  = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_CPU-1:0] cpu_irq
);
   localparam int unsigned WORDS  = words_for(NUM_SRC);
   localparam int unsigned CPU_W  = idx_width(NUM_CPU);
   localparam int unsigned WIDX_W = idx_width(WORDS);
   localparam int unsigned SPAN   = NUM_CPU * 8 * WORDS;

   // R1
   initial begin
      src_count_chk: assert (NUM_SRC == 32 || NUM_SRC == 64 || NUM_SRC == 128)
         else $fatal(1, "NUM_SRC must be 32, 64 or 128");
      addr_span_chk: assert (NUM_CPU >= 1 && ADDR_W <= 32 && (64'(1) << ADDR_W) >= 64'(SPAN))
         else $fatal(1, "ADDR_W too small for the bank windows");
   end

   logic              hit, is_stat;
   logic [CPU_W-1:0]  cpu;
   logic [WIDX_W-1:0] widx;
   logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_all, pend_all;

   irqr_addr_dec #(.NUM_CPU(NUM_CPU), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .hit(hit), .cpu(cpu), .is_stat(is_stat), .widx(widx)
   );

   genvar c;
   generate
      for (c = 0; c < NUM_CPU; c++) begin : g_cpu
         logic wr_here;
         // R5, R7, R9: only mask words of the addressed bank are written
         assign wr_here = bus_sel && bus_wr && hit && !is_stat && (cpu == CPU_W'(c));
         irqr_cpu_bank #(.WORDS(WORDS)) u_bank (
            .clk(clk), .rst_n(rst_n), .src(irq_src), .wr_en(wr_here),
            .widx(widx), .wdata(bus_wdata),
            .mask(mask_all[c]), .pend(pend_all[c]), .irq_o(cpu_irq[c])
         );
      end
   endgenerate

   // R10: combinational read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && hit) begin
         for (int i = 0; i < NUM_CPU; i++) begin
            if (cpu == CPU_W'(i))
               bus_rdata = is_stat ? pend_all[i][32*widx +: 32]
                                   : mask_all[i][32*widx +: 32];
         end
      end
   end

   // R5
   stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && is_stat) |=> $stable(mask_all));
   // R9
   unused_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !hit) |=> $stable(mask_all));
   // R9
   unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && (32'(bus_addr) >= SPAN)) |-> (bus_rdata == '0));
   // R8
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cpu_irq == '0));
   // R4
   pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && is_stat) |-> ((bus_rdata & ~irq_src[32*widx +: 32]) == '0));
endmodule

// File: tb/tb_cpu_irq_router.sv
module tb_cpu_irq_router;
   localparam int NSRC = 64;   // R1: two words per bank
   localparam int NCPU = 3;
   localparam int AW   = 8;
   localparam int W    = NSRC / 32;

   logic            clk = 0, rst_n = 0;
   logic [NSRC-1:0] irq_src = '0;
   logic            bus_sel = 0, bus_wr = 0;
   logic [AW-1:0]   bus_addr = '0;
   logic [31:0]     bus_wdata = '0, bus_rdata;
   logic [NCPU-1:0] cpu_irq;

   int checks = 0, errors = 0;
   logic [31:0]     en_m [NCPU][W];
   logic [NCPU-1:0] exp_irq;

   cpu_irq_router #(.NUM_SRC(NSRC), .NUM_CPU(NCPU), .ADDR_W(AW)) dut (.*);

   always #10 clk = ~clk;   // 50 MHz

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCPU; c++)
            for (int k = 0; k < W; k++) en_m[c][k] <= 0;
         exp_irq <= '0;
      end else begin
         int a, c, o;
         for (int i = 0; i < NCPU; i++) begin
            logic any;
            any = 0;
            for (int k = 0; k < W; k++)
               if ((irq_src[32*k +: 32] & en_m[i][k]) != 0) any = 1;
            exp_irq[i] <= any;
         end
         if (bus_sel && bus_wr) begin
            a = int'(bus_addr) / 4; c = a / (2*W); o = a % (2*W);
            if (c < NCPU && o < W) en_m[c][o] <= bus_wdata;
         end
      end
   end

   function automatic logic [31:0] exp_read();
      int a, c, o;
      if (!bus_sel || bus_wr) return 0;
      a = int'(bus_addr) / 4; c = a / (2*W); o = a % (2*W);
      if (c >= NCPU) return 0;
      if (o < W) return en_m[c][o];
      return irq_src[32*(o-W) +: 32] & en_m[c][o-W];
   endfunction

   function automatic string read_tag();
      int a;
      a = int'(bus_addr) / 4;
      if (!bus_sel || bus_wr) return "R10";
      if (a / (2*W) >= NCPU) return "R9";
      if (a % (2*W) >= W) return "R4";
      return "R3";
   endfunction

   // compare on every clock, away from the active edge
   always @(negedge clk) if (rst_n) begin
      checks++;
      if (cpu_irq !== exp_irq) begin
         errors++;
         $display("FAIL R6 cpu_irq actual %b expected %b", cpu_irq, exp_irq);
      end
      checks++;
      if (bus_rdata !== exp_read()) begin
         errors++;
         $display("FAIL %s rdata @%h actual %h expected %h", read_tag(), bus_addr, bus_rdata, exp_read());
      end
   end

   task automatic step(input logic s, input logic w, input int a, input logic [31:0] d);
      @(posedge clk); #3;
      bus_sel = s; bus_wr = w; bus_addr = AW'(a); bus_wdata = d;
   endtask

   task automatic rd(input int a); step(1, 0, a, 0); endtask
   task automatic wr(input int a, input logic [31:0] d); step(1, 1, a, d); endtask
   task automatic idle(); step(0, 0, 0, 0); endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1;
      // R8: reset state, all lines high but nothing enabled
      irq_src = '1;
      idle(); idle();
      checks++;
      if (cpu_irq !== '0) begin errors++; $display("FAIL R8 cpu_irq actual %b expected 0", cpu_irq); end
      for (int a = 0; a < 48; a += 4) rd(a);
      irq_src = '0;
      // R3/R6: source 0 to CPU0
      wr(0, 32'h1); idle();
      irq_src[0] = 1; idle(); idle(); rd(0); rd(8);
      irq_src[0] = 0; idle(); idle();
      // R5: pending write ignored
      wr(8, 32'hFFFF_FFFF); rd(0); wr(16+12, 32'hFFFF_FFFF); rd(16+4);
      // R9: unused addresses
      wr(48, 32'hFFFF_FFFF); wr(200, 32'hFFFF_FFFF); rd(48); rd(252);
      // R2: low address bits ignored, source 63 in word 1
      wr(16+4+3, 32'h8000_0000); wr(32+4+1, 32'h8000_0000);
      // R7: same source in two banks, CPU0 untouched
      irq_src[63] = 1; idle(); idle(); rd(16+12); rd(32+12); rd(4);
      wr(16+4, 32'h0); idle(); idle();   // R7 disable only CPU1
      irq_src[63] = 0; idle(); idle();
      // random mix
      for (int n = 0; n < 2000; n++) begin
         int r;
         r = $urandom_range(0, 3);
         if (r == 0) irq_src[$urandom_range(0, NSRC-1)] ^= 1'b1;
         case ($urandom_range(0, 3))
            0: wr($urandom_range(0, 63), $urandom);
            1: rd($urandom_range(0, 63));
            2: rd($urandom_range(0, 255));
            default: idle();
         endcase
      end
      idle(); idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule